// File: doc/BRIEF.md
# Switch Overcurrent Deglitch and Recovery Controller

This block guards one power switch of a half-bridge. It watches a digital overcurrent flag from an external comparator, but only while the PWM command for that switch is high. A fault is declared only after the flag has stayed high for an unbroken run of clock cycles, which filters out switching noise. Once a fault is declared, the gate enable is forced low and an active-low fault pin is pulled low.

The block recovers from a fault in one of two ways. In the first, the PWM command stays low for a long fixed time and the block then resumes normal driving. In the second, when cycle-by-cycle mode is selected, the next rising PWM edge clears the fault and drives the switch again in that same cycle. A build-time parameter removes the second path for switches sensed through a low-side shunt, which must always use the timed recovery. Both timer lengths are parameters counted in clock cycles.

All pins are plain level signals sampled on the clock. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `ocp_guard`

## Requirements
- R1: While `pwm_in` is low, `oc_flag` is ignored: no fault is declared however long the flag stays high.
- R2: A fault is declared on the clock edge that samples the DEGLITCH_CYC-th consecutive cycle with `pwm_in` and `oc_flag` both high, and not on any earlier edge.
- R3: If the qualified flag drops before the deglitch run completes, the run restarts from zero, so a full DEGLITCH_CYC run is needed again.
- R4: While a fault is held, `gate_en` is 0 and `fault_n` is 0, whatever `pwm_in` does, until one of the recovery paths clears the fault.
- R5: In a fault, once `pwm_in` has been low for RETRY_CYC consecutive sampled cycles, the fault clears on that edge: `fault_n` returns to 1 and `gate_en` follows `pwm_in` again.
- R6: With `cbc_en` = 0, a rising `pwm_in` edge during a fault does not clear it, and any cycle with `pwm_in` high restarts the retry count from zero.
- R7: With `cbc_en` = 1 and CBC_ALLOWED = 1, a rising `pwm_in` edge (low at the previous clock edge, high now) during a fault clears it in the same cycle: `fault_n` = 1 and `gate_en` = 1 right away, with no clock edge needed.
- R8: With CBC_ALLOWED = 0 (shunt-sensed variant), `cbc_en` has no effect and only the timed retry clears a fault.
- R9: A synchronous reset (`rst` = 1 at a clock edge) returns the block to the normal state with `fault_n` = 1, even in the middle of a fault.
- R10: Outside a fault, `gate_en` equals `pwm_in` and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | PWM command for this switch |
| oc_flag | input | 1 | Overcurrent comparator output, high when over the threshold |
| cbc_en | input | 1 | Selects cycle-by-cycle recovery (takes effect only when CBC_ALLOWED = 1) |
| gate_en | output | 1 | Gated drive enable for the switch |
| fault_n | output | 1 | Fault indicator, low while a fault is held |

## Verification
The embedded properties check on every cycle that a fault can only start from a cycle with PWM and flag both high, that the deglitch count never passes its limit and clears whenever qualification drops, that a high PWM level zeroes the retry count, that the fault pin and the gate enable are never active together, and that reset releases the pin. Only the bench scenarios can show the exact cycle on which a fault is declared and on which each recovery path releases it. They also show that a glitch restarts the full deglitch run, that a PWM pulse during the wait pushes the retry out, and that the shunt variant ignores the mode select.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {
    GUARD_RUN   = 1'b0,
    GUARD_FAULT = 1'b1
  } guard_st_e;
endpackage

// File: rtl/ocp_deglitch.sv
module ocp_deglitch #(
  parameter int unsigned CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic qual,
  output logic confirm
);
  localparam int unsigned W = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] run_q;

  assign confirm = qual && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !qual || confirm) run_q <= '0;
    else                         run_q <= run_q + 1'b1;
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_q <= LAST); // R2
  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
    !qual |=> (run_q == '0)); // R3
endmodule

// File: rtl/ocp_retry_timer.sv
module ocp_retry_timer #(
  parameter int unsigned CYC = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic pwm_in,
  output logic expire
);
  localparam int unsigned W = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic       idle_low;
  logic [W-1:0] wait_q;

  assign idle_low = active && !pwm_in;
  assign expire   = idle_low && (wait_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !idle_low || expire) wait_q <= '0;
    else                            wait_q <= wait_q + 1'b1;
  end

  AST_PWM_RESTARTS_WAIT: assert property (@(posedge clk) disable iff (rst)
    pwm_in |=> (wait_q == '0)); // R6
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    wait_q <= LAST); // R5
endmodule

// File: rtl/ocp_edge_det.sv
module ocp_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig;
  end

  assign rise = sig && !sig_q;
endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
  import ocp_pkg::*;
#(
  parameter int unsigned DEGLITCH_CYC = 1000,
  parameter int unsigned RETRY_CYC    = 2000000,
  parameter bit          CBC_ALLOWED  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_in,
  input  logic oc_flag,
  input  logic cbc_en,
  output logic gate_en,
  output logic fault_n
);
  guard_st_e st_q, st_d;
  logic      in_run, in_fault;
  logic      qual, confirm, expire, pwm_rise;
  logic      cbc_ok, cbc_clear;

  assign in_run   = (st_q == GUARD_RUN);
  assign in_fault = (st_q == GUARD_FAULT);
  assign qual     = in_run && pwm_in && oc_flag;

  ocp_deglitch #(.CYC(DEGLITCH_CYC)) deglitch_i (
    .clk(clk), .rst(rst), .qual(qual), .confirm(confirm)
  );

  ocp_retry_timer #(.CYC(RETRY_CYC)) retry_i (
    .clk(clk), .rst(rst), .active(in_fault), .pwm_in(pwm_in), .expire(expire)
  );

  ocp_edge_det pwm_edge_i (
    .clk(clk), .rst(rst), .sig(pwm_in), .rise(pwm_rise)
  );

  generate
    if (CBC_ALLOWED) begin : g_cbc
      assign cbc_ok = cbc_en;
    end else begin : g_retry_only
      assign cbc_ok = cbc_en & 1'b0;
    end
  endgenerate

  assign cbc_clear = in_fault && cbc_ok && pwm_rise;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GUARD_RUN:   if (confirm) st_d = GUARD_FAULT;
      GUARD_FAULT: if (cbc_clear || expire) st_d = GUARD_RUN;
      default:     st_d = GUARD_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= GUARD_RUN;
    else     st_q <= st_d;
  end

  assign gate_en = pwm_in && (in_run || cbc_clear);
  assign fault_n = in_run || cbc_clear;

  AST_FAULT_NEEDS_QUAL: assert property (@(posedge clk) disable iff (rst)
    (in_fault && $past(st_q) == GUARD_RUN) |-> $past(pwm_in && oc_flag)); // R1
  AST_GATE_OFF_WHEN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> !gate_en); // R4
  AST_RESET_RELEASES_PIN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> fault_n); // R9
endmodule

// File: tb/ocp_guard_tb_top.sv
module ocp_guard_tb_top;
  localparam int unsigned DG = 8;
  localparam int unsigned RT = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_in = 1'b0, oc_flag = 1'b0, cbc_en = 1'b0;
  logic gate_en, fault_n;
  logic s_pwm = 1'b0, s_flag = 1'b0, s_cbc = 1'b1;
  logic s_gate, s_fault_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ocp_guard #(.DEGLITCH_CYC(DG), .RETRY_CYC(RT), .CBC_ALLOWED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .oc_flag(oc_flag), .cbc_en(cbc_en),
    .gate_en(gate_en), .fault_n(fault_n)
  );

  ocp_guard #(.DEGLITCH_CYC(DG), .RETRY_CYC(RT), .CBC_ALLOWED(1'b0)) dut_shunt_i (
    .clk(clk), .rst(rst), .pwm_in(s_pwm), .oc_flag(s_flag), .cbc_en(s_cbc),
    .gate_en(s_gate), .fault_n(s_fault_n)
  );

  typedef struct packed {
    logic       pwm;
    logic       flag;
    logic       cbc;
    logic [7:0] hold;
    logic       exp_gate;
    logic       exp_fn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 8'd3,  1'b1, 1'b1, 4'd10}, // R10 normal drive
    '{1'b1, 1'b1, 1'b0, 8'd7,  1'b1, 1'b1, 4'd2},  // R2 one short of the run
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0, 1'b0, 4'd2},  // R2 declared on the 8th
    '{1'b0, 1'b0, 1'b0, 8'd19, 1'b0, 1'b0, 4'd4},  // R4 held while waiting
    '{1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 1'b1, 4'd5},  // R5 released on the 20th
    '{1'b1, 1'b1, 1'b0, 8'd5,  1'b1, 1'b1, 4'd3},  // R3 partial run
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b1, 4'd3},  // R3 flag glitch ends
    '{1'b1, 1'b1, 1'b0, 8'd7,  1'b1, 1'b1, 4'd3},  // R3 full run needed again
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0, 1'b0, 4'd3},  // R3 declared
    '{1'b0, 1'b0, 1'b1, 8'd2,  1'b0, 1'b0, 4'd4},  // R4 still held
    '{1'b1, 1'b0, 1'b1, 8'd0,  1'b1, 1'b1, 4'd7},  // R7 cleared on the edge
    '{1'b1, 1'b0, 1'b1, 8'd2,  1'b1, 1'b1, 4'd7},  // R7 stays driven
    '{1'b0, 1'b1, 1'b0, 8'd12, 1'b0, 1'b1, 4'd1},  // R1 flag ignored with PWM low
    '{1'b1, 1'b1, 1'b0, 8'd8,  1'b0, 1'b0, 4'd1},  // R1 monitored once PWM high
    '{1'b0, 1'b0, 1'b0, 8'd10, 1'b0, 1'b0, 4'd6},  // R6 partial wait
    '{1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 4'd6},  // R6 rising edge no clear
    '{1'b1, 1'b0, 1'b0, 8'd2,  1'b0, 1'b0, 4'd6},  // R6 PWM high restarts
    '{1'b0, 1'b0, 1'b0, 8'd19, 1'b0, 1'b0, 4'd6},  // R6 full wait again
    '{1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 1'b1, 4'd6}   // R6 released
  };

  task automatic check(input string req, input logic act_g, input logic act_f,
                       input logic exp_g, input logic exp_f);
    checks++;
    if (act_g !== exp_g || act_f !== exp_f) begin
      failures++;
      $display("FAIL %s: gate_en=%b fault_n=%b expected gate_en=%b fault_n=%b",
               req, act_g, act_f, exp_g, exp_f);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    edges(3);
    check("R9 reset state", gate_en, fault_n, 1'b0, 1'b1);
    check("R9 reset state shunt", s_gate, s_fault_n, 1'b0, 1'b1);
    rst = 1'b0;
    edges(1);

    for (int i = 0; i < NV; i++) begin
      pwm_in  = VEC[i].pwm;
      oc_flag = VEC[i].flag;
      cbc_en  = VEC[i].cbc;
      if (VEC[i].hold == 0) #1;
      else edges(int'(VEC[i].hold));
      check($sformatf("R%0d vector %0d", VEC[i].req, i), gate_en, fault_n,
            VEC[i].exp_gate, VEC[i].exp_fn);
    end

    // R9: reset in the middle of a fault
    pwm_in = 1'b1; oc_flag = 1'b1; cbc_en = 1'b0;
    edges(DG);
    check("R9 fault before reset", gate_en, fault_n, 1'b0, 1'b0);
    rst = 1'b1;
    edges(1);
    check("R9 reset releases", gate_en, fault_n, 1'b1, 1'b1);
    rst = 1'b0; pwm_in = 1'b0; oc_flag = 1'b0;
    edges(2);

    // R8: shunt variant ignores the mode select
    s_pwm = 1'b1; s_flag = 1'b1;
    edges(DG);
    check("R8 shunt fault declared", s_gate, s_fault_n, 1'b0, 1'b0);
    s_pwm = 1'b0; s_flag = 1'b0;
    edges(3);
    s_pwm = 1'b1;
    #1;
    check("R8 shunt edge no clear", s_gate, s_fault_n, 1'b0, 1'b0);
    edges(1);
    check("R8 shunt still held", s_gate, s_fault_n, 1'b0, 1'b0);
    s_pwm = 1'b0;
    edges(RT - 1);
    check("R5 shunt wait not done", s_gate, s_fault_n, 1'b0, 1'b0);
    edges(1);
    check("R5 shunt retry release", s_gate, s_fault_n, 1'b0, 1'b1);
    s_pwm = 1'b1;
    #1;
    check("R10 shunt drives again", s_gate, s_fault_n, 1'b1, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule